// File: doc/BRIEF.md
# Masked Sixteen-Lane Vector Integer Execute Unit

This block is the execute slice of a wide vector unit. It holds a file of wide vector registers, each a row of equal-width integer elements, and a small file of lane masks. In one clock it reads up to three source vectors, passes the second source through a lane-rearrange stage, and runs an add, a multiply or a three-operand multiply-add in every lane at once. It then writes the result back to a destination register, but only in the lanes whose bit is set in the chosen mask. Lanes whose mask bit is clear keep their old contents, so data-dependent branches can be flattened into masked straight-line code.

A separate whole-register load port fills vector registers. A mask-write port fills masks. A combinational observe port reads back any vector register. Reads of all kinds are combinational. The operation's write lands at the clock edge that ends its single execute cycle.

Top module: `vlx_exec_top`

## Requirements
- R1: With the add operation (op code 0), each written lane of the destination receives the 32-bit wrapped sum of lane i of source A and lane i of the rearranged source B. Lane i occupies bits [32i+31:32i].
- R2: With op code 1, each written lane receives the low 32 bits of the product of source A and the rearranged source B in that lane.
- R3: With op code 2, each written lane receives the low 32 bits of A times rearranged B, plus source C in that lane.
- R4: Rearrange code 1 copies lane 0 of source B into every lane before the operation.
- R5: Rearrange code 2 exchanges each even lane 2k of source B with its odd neighbour 2k+1. Codes 0 and 3 leave source B unchanged.
- R6: A lane whose bit i is clear in the selected mask keeps its previous destination value. Bit i of a mask governs lane i.
- R7: Mask index 0 always reads as all ones, so every lane is written. Writes to mask index 0 are ignored.
- R8: Mask indices 1 to 7 hold the last 16-bit value written to them through the mask-write port.
- R9: A cycle with no issued operation, or one carrying the reserved op code 3, changes no vector register.
- R10: When a load and an operation target the same register in the same cycle, the load's value is stored.
- R11: A source register that is also the destination supplies its value from before the write. The result is visible on the observe port right after the clock edge.
- R12: After reset, every vector register and every mask 1 to 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 2 | 0 add, 1 multiply, 2 multiply-add, 3 reserved |
| issue_dst | input | 5 | Destination vector register |
| issue_src_a | input | 5 | Source A register |
| issue_src_b | input | 5 | Source B register (rearranged) |
| issue_src_c | input | 5 | Source C register (addend) |
| issue_swz | input | 2 | Rearrange code for source B |
| issue_mask | input | 3 | Mask register selecting written lanes |
| ld_valid | input | 1 | Whole-register load strobe |
| ld_idx | input | 5 | Register to load |
| ld_data | input | 512 | Load value |
| mk_valid | input | 1 | Mask write strobe |
| mk_idx | input | 3 | Mask register to write |
| mk_data | input | 16 | Mask value |
| peek_idx | input | 5 | Register to observe |
| peek_data | output | 512 | Observed register contents |

## Verification
The hardest case to reach from the ports is a lane-partial write whose kept lanes must survive. Two conditions have to hold at once: the destination must already hold distinct non-zero data in every lane, and the selected mask must be programmed to a sparse pattern beforehand. The stimulus therefore first loads the destination with a per-lane pattern and writes an alternating mask. Only then does it issue the operation, with a swizzle that moves data across lanes, so that a lane-index mix-up shows in the kept lanes. A same-cycle load and operation on one register, and an operation whose destination is also its source, cover the write-ordering corners.

// File: rtl/vlx_pkg.sv
package vlx_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MUL = 2'd1,
    OP_FMA = 2'd2,
    OP_RSV = 2'd3
  } vop_e;

  typedef enum logic [1:0] {
    SW_IDENT  = 2'd0,
    SW_BCAST  = 2'd1,
    SW_PAIR   = 2'd2,
    SW_IDENT2 = 2'd3
  } swz_e;
endpackage

// File: rtl/vlx_swizzle.sv
module vlx_swizzle #(
  parameter int unsigned LANES = 16,
  parameter int unsigned EW    = 32,
  localparam int unsigned VW   = LANES * EW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  vlx_pkg::swz_e sel,
  input  logic [VW-1:0] vin,
  output logic [VW-1:0] vout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int unsigned PARTNER = i ^ 1;
    always_comb begin
      case (sel)
        vlx_pkg::SW_BCAST: vout[i*EW +: EW] = vin[0 +: EW];
        vlx_pkg::SW_PAIR:  vout[i*EW +: EW] = vin[PARTNER*EW +: EW];
        default:           vout[i*EW +: EW] = vin[i*EW +: EW];
      endcase
    end

    // R4
    bcast_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == vlx_pkg::SW_BCAST) |-> (vout[i*EW +: EW] == vout[0 +: EW]));

    // R5
    pair_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == vlx_pkg::SW_PAIR) |-> (vout[PARTNER*EW +: EW] == vin[i*EW +: EW]));
  end
endmodule

// File: rtl/vlx_lanes.sv
module vlx_lanes #(
  parameter int unsigned LANES = 16,
  parameter int unsigned EW    = 32,
  localparam int unsigned VW   = LANES * EW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  vlx_pkg::vop_e    op,
  input  logic [VW-1:0]    va,
  input  logic [VW-1:0]    vb,
  input  logic [VW-1:0]    vc,
  input  logic [LANES-1:0] mask,
  output logic [VW-1:0]    res,
  output logic [LANES-1:0] lane_we
);
  function automatic logic [EW-1:0] lane_calc(input vlx_pkg::vop_e o,
                                              input logic [EW-1:0] a,
                                              input logic [EW-1:0] b,
                                              input logic [EW-1:0] c);
    logic [2*EW-1:0] prod;
    prod = {{EW{1'b0}}, a} * {{EW{1'b0}}, b};
    case (o)
      vlx_pkg::OP_ADD: return a + b;
      vlx_pkg::OP_MUL: return prod[EW-1:0];
      vlx_pkg::OP_FMA: return prod[EW-1:0] + c;
      default:         return a;
    endcase
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_alu
    assign res[i*EW +: EW] = lane_calc(op, va[i*EW +: EW], vb[i*EW +: EW], vc[i*EW +: EW]);
  end

  assign lane_we = (valid && op != vlx_pkg::OP_RSV) ? mask : '0;

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid || op == vlx_pkg::OP_RSV) |-> (lane_we == '0));
endmodule

// File: rtl/vlx_regfile.sv
module vlx_regfile #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned LANES = 16,
  parameter int unsigned EW    = 32,
  localparam int unsigned VW   = LANES * EW,
  localparam int unsigned IW   = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IW-1:0]    ld_idx,
  input  logic [VW-1:0]    ld_data,
  input  logic [LANES-1:0] ex_we,
  input  logic [IW-1:0]    ex_idx,
  input  logic [VW-1:0]    ex_data,
  input  logic [IW-1:0]    ra,
  input  logic [IW-1:0]    rb,
  input  logic [IW-1:0]    rc,
  input  logic [IW-1:0]    rp,
  output logic [VW-1:0]    rda,
  output logic [VW-1:0]    rdb,
  output logic [VW-1:0]    rdc,
  output logic [VW-1:0]    rdp
);
  logic [VW-1:0] regs [NREGS];
  logic [VW-1:0] ex_old;
  logic          ld_hits_ex;

  assign rda        = regs[ra];
  assign rdb        = regs[rb];
  assign rdc        = regs[rc];
  assign rdp        = regs[rp];
  assign ex_old     = regs[ex_idx];
  assign ld_hits_ex = ld_valid && (ld_idx == ex_idx);

  for (genvar r = 0; r < NREGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[r] <= '0;
      end else if (ld_valid && ld_idx == IW'(r)) begin
        regs[r] <= ld_data;
      end else if (ex_idx == IW'(r)) begin
        for (int l = 0; l < LANES; l++) begin
          if (ex_we[l]) regs[r][l*EW +: EW] <= ex_data[l*EW +: EW];
        end
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_keep
    // R6
    masked_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hits_ex && !ex_we[l]) |=>
        (regs[$past(ex_idx)][l*EW +: EW] == $past(ex_old[l*EW +: EW])));
  end

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (regs[$past(ld_idx)] == $past(ld_data)));
endmodule

// File: rtl/vlx_maskfile.sv
module vlx_maskfile #(
  parameter int unsigned NMASK = 8,
  parameter int unsigned LANES = 16,
  localparam int unsigned MW   = $clog2(NMASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [MW-1:0]    wr_idx,
  input  logic [LANES-1:0] wr_data,
  input  logic [MW-1:0]    rd_idx,
  output logic [LANES-1:0] rd_mask
);
  logic [LANES-1:0] mregs [NMASK];

  assign mregs[0] = '1;

  for (genvar m = 1; m < NMASK; m++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mregs[m] <= '0;
      else if (wr_valid && wr_idx == MW'(m))     mregs[m] <= wr_data;
    end
  end

  assign rd_mask = mregs[rd_idx];

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_idx != '0) |=> (mregs[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/vlx_exec_top.sv
module vlx_exec_top #(
  parameter int unsigned NREGS = 32,
  parameter int unsigned LANES = 16,
  parameter int unsigned EW    = 32,
  parameter int unsigned NMASK = 8,
  localparam int unsigned VW   = LANES * EW,
  localparam int unsigned IW   = $clog2(NREGS),
  localparam int unsigned MW   = $clog2(NMASK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_valid,
  input  logic [1:0]       issue_op,
  input  logic [IW-1:0]    issue_dst,
  input  logic [IW-1:0]    issue_src_a,
  input  logic [IW-1:0]    issue_src_b,
  input  logic [IW-1:0]    issue_src_c,
  input  logic [1:0]       issue_swz,
  input  logic [MW-1:0]    issue_mask,
  input  logic             ld_valid,
  input  logic [IW-1:0]    ld_idx,
  input  logic [VW-1:0]    ld_data,
  input  logic             mk_valid,
  input  logic [MW-1:0]    mk_idx,
  input  logic [LANES-1:0] mk_data,
  input  logic [IW-1:0]    peek_idx,
  output logic [VW-1:0]    peek_data
);
  logic [VW-1:0]    src_a, src_b_raw, src_b, src_c, result;
  logic [LANES-1:0] sel_mask, lane_we;
  vlx_pkg::vop_e    op;
  vlx_pkg::swz_e    swz;

  assign op  = vlx_pkg::vop_e'(issue_op);
  assign swz = vlx_pkg::swz_e'(issue_swz);

  vlx_regfile #(.NREGS(NREGS), .LANES(LANES), .EW(EW)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .ex_we(lane_we), .ex_idx(issue_dst), .ex_data(result),
    .ra(issue_src_a), .rb(issue_src_b), .rc(issue_src_c), .rp(peek_idx),
    .rda(src_a), .rdb(src_b_raw), .rdc(src_c), .rdp(peek_data)
  );

  vlx_maskfile #(.NMASK(NMASK), .LANES(LANES)) u_mf (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(mk_valid), .wr_idx(mk_idx), .wr_data(mk_data),
    .rd_idx(issue_mask), .rd_mask(sel_mask)
  );

  vlx_swizzle #(.LANES(LANES), .EW(EW)) u_swz (
    .clk(clk), .rst_n(rst_n), .sel(swz), .vin(src_b_raw), .vout(src_b)
  );

  vlx_lanes #(.LANES(LANES), .EW(EW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .valid(issue_valid), .op(op),
    .va(src_a), .vb(src_b), .vc(src_c), .mask(sel_mask),
    .res(result), .lane_we(lane_we)
  );

  // R7
  mask0_full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_mask == '0 && op != vlx_pkg::OP_RSV) |-> (lane_we == '1));
endmodule

// File: tb/vlx_exec_top_tb.sv
module vlx_exec_top_tb_top;
  localparam int CLK_P = 10;
  localparam int L = 16;
  localparam int VW = 512;

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0;
  logic [1:0] issue_op = 0, issue_swz = 0;
  logic [4:0] issue_dst = 0, issue_src_a = 0, issue_src_b = 0, issue_src_c = 0;
  logic [2:0] issue_mask = 0;
  logic ld_valid = 0;
  logic [4:0] ld_idx = 0;
  logic [VW-1:0] ld_data = 0;
  logic mk_valid = 0;
  logic [2:0] mk_idx = 0;
  logic [15:0] mk_data = 0;
  logic [4:0] peek_idx = 0;
  logic [VW-1:0] peek_data;

  int checks = 0, errors = 0;
  logic [VW-1:0] mreg [32];
  logic [15:0]   mmsk [8];

  always #(CLK_P/2) clk = ~clk;

  vlx_exec_top dut_i (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_dst(issue_dst), .issue_src_a(issue_src_a), .issue_src_b(issue_src_b),
    .issue_src_c(issue_src_c), .issue_swz(issue_swz), .issue_mask(issue_mask),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .mk_valid(mk_valid), .mk_idx(mk_idx), .mk_data(mk_data),
    .peek_idx(peek_idx), .peek_data(peek_data)
  );

  function automatic logic [VW-1:0] pattern(input int seed);
    logic [VW-1:0] v;
    for (int i = 0; i < L; i++) v[i*32 +: 32] = 32'(seed) * 32'h9E3779B1 + 32'(i * 7 + 3);
    return v;
  endfunction

  function automatic logic [VW-1:0] model_op(input int op, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [VW-1:0] c, input int swz,
      input logic [15:0] m, input logic [VW-1:0] old);
    logic [VW-1:0] r;
    logic [31:0] x, y, z;
    r = old;
    if (op == 3) return old;
    for (int i = 0; i < L; i++) begin
      x = a[i*32 +: 32];
      z = c[i*32 +: 32];
      if (swz == 1)      y = b[31:0];
      else if (swz == 2) y = b[(i ^ 1)*32 +: 32];
      else               y = b[i*32 +: 32];
      if (m[i]) begin
        if (op == 0)      r[i*32 +: 32] = x + y;
        else if (op == 1) r[i*32 +: 32] = x * y;
        else              r[i*32 +: 32] = x * y + z;
      end
    end
    return r;
  endfunction

  task automatic check_reg(input int idx, input string req);
    peek_idx = 5'(idx);
    #1;
    checks++;
    if (peek_data !== mreg[idx]) begin
      errors++;
      $display("FAIL %s reg %0d actual %h expected %h", req, idx, peek_data, mreg[idx]);
    end
  endtask

  task automatic load(input int idx, input logic [VW-1:0] d);
    @(negedge clk);
    ld_valid = 1; ld_idx = 5'(idx); ld_data = d;
    @(negedge clk);
    ld_valid = 0;
    mreg[idx] = d;
  endtask

  task automatic set_mask(input int idx, input logic [15:0] d);
    @(negedge clk);
    mk_valid = 1; mk_idx = 3'(idx); mk_data = d;
    @(negedge clk);
    mk_valid = 0;
    if (idx != 0) mmsk[idx] = d;
  endtask

  // issues one op; optionally a load in the same cycle
  task automatic exec(input int op, input int d, input int a, input int b, input int c,
                      input int swz, input int m, input bit with_ld, input int lidx,
                      input logic [VW-1:0] ldat);
    logic [VW-1:0] nv;
    @(negedge clk);
    issue_valid = 1; issue_op = 2'(op); issue_dst = 5'(d);
    issue_src_a = 5'(a); issue_src_b = 5'(b); issue_src_c = 5'(c);
    issue_swz = 2'(swz); issue_mask = 3'(m);
    ld_valid = with_ld; ld_idx = 5'(lidx); ld_data = ldat;
    nv = model_op(op, mreg[a], mreg[b], mreg[c], swz, mmsk[m], mreg[d]);
    @(negedge clk);
    issue_valid = 0; ld_valid = 0;
    mreg[d] = nv;
    if (with_ld) mreg[lidx] = ldat;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mreg[i] = '0;
    mmsk[0] = 16'hFFFF;
    for (int i = 1; i < 8; i++) mmsk[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    check_reg(0, "R12"); check_reg(17, "R12"); check_reg(31, "R12");

    for (int i = 1; i < 10; i++) load(i, pattern(i));
    check_reg(4, "R10 load");

    exec(0, 10, 1, 2, 0, 0, 0, 0, 0, '0);  check_reg(10, "R1 add");
    exec(1, 11, 3, 4, 0, 0, 0, 0, 0, '0);  check_reg(11, "R2 mul");
    exec(2, 12, 5, 6, 7, 0, 0, 0, 0, '0);  check_reg(12, "R3 fma");
    exec(0, 13, 1, 8, 0, 1, 0, 0, 0, '0);  check_reg(13, "R4 broadcast");
    exec(2, 14, 2, 9, 3, 1, 0, 0, 0, '0);  check_reg(14, "R4 broadcast fma");
    exec(1, 15, 6, 7, 0, 2, 0, 0, 0, '0);  check_reg(15, "R5 pair swap");
    exec(0, 16, 4, 5, 0, 3, 0, 0, 0, '0);  check_reg(16, "R5 code3 identity");

    // R6 / R8 partial writes onto preloaded destinations
    set_mask(1, 16'hAAAA);
    set_mask(2, 16'h8001);
    set_mask(3, 16'h0000);
    load(20, pattern(20)); load(21, pattern(21)); load(22, pattern(22));
    exec(0, 20, 1, 2, 0, 2, 1, 0, 0, '0);  check_reg(20, "R6 mask AAAA swap");
    exec(2, 21, 3, 4, 5, 1, 2, 0, 0, '0);  check_reg(21, "R6 mask 8001");
    exec(1, 22, 6, 7, 0, 0, 3, 0, 0, '0);  check_reg(22, "R6 mask zero");
    set_mask(1, 16'h00F0);
    exec(0, 22, 8, 9, 0, 0, 1, 0, 0, '0);  check_reg(22, "R8 mask rewritten");

    // R7 writes to mask 0 ignored
    set_mask(0, 16'h0000);
    exec(0, 23, 1, 1, 0, 0, 0, 0, 0, '0);  check_reg(23, "R7 mask0 all ones");

    // R9 idle cycles and reserved op
    repeat (3) @(negedge clk);
    check_reg(10, "R9 idle");
    exec(3, 12, 1, 2, 3, 0, 0, 0, 0, '0);  check_reg(12, "R9 reserved op");

    // R10 same-cycle load and op on one register; and load to a different reg
    exec(0, 24, 1, 2, 0, 0, 0, 1, 24, pattern(99));  check_reg(24, "R10 load wins");
    exec(0, 25, 1, 2, 0, 0, 0, 1, 26, pattern(77));
    check_reg(25, "R10 op alongside load"); check_reg(26, "R10 other load");

    // R11 destination aliases sources
    exec(2, 5, 5, 5, 5, 2, 0, 0, 0, '0);   check_reg(5, "R11 alias fma");
    exec(0, 6, 6, 6, 0, 1, 1, 0, 0, '0);   check_reg(6, "R11 alias masked");

    // full sweep: nothing else disturbed
    for (int i = 0; i < 32; i++) check_reg(i, "R9 sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule